// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block connects a synchronous on-chip request port to an external asynchronous static memory of 128K bytes. A caller presents one request at a time: a read/write flag, a 17-bit word address and, for writes, a data byte. The controller then runs the memory strobes through a fixed sequence and reports completion with a one-cycle `done` pulse. Read data appears on `rdata` in the same cycle as `done`.

The memory has no clock, so each nanosecond limit becomes a cycle-count parameter. The defaults assume a 100 MHz system clock. The address is registered when a request is accepted, so it is already valid when the two chip enables go active. The chip enables have opposite polarities and always switch together. Writes are timed by the write-enable strobe, which is preceded by a setup window and followed by a recovery window. The controller drives the data bus only inside the write pulse, and only after the memory has had a full cycle to release it. A write that directly follows a read first spends a standby cycle on the bus, so the two drivers cannot overlap. Between accesses the memory is held in standby.

Top module: `asram_port`

## Requirements
- R1: After reset, and in every cycle in which `ready` is 1, the memory is in standby with all strobes inactive: `mem_sel_n`=1, `mem_sel`=0, `mem_oe_n`=1, `mem_we_n`=1 and `mem_dq_oe`=0.
- R2: `mem_sel_n` is the complement of `mem_sel` in every cycle.
- R3: A request is taken only in a cycle in which `ready` is 1. While an access is in progress `ready` is 0, and a `req_valid` that arrives during that time starts no access and changes no memory contents.
- R4: With the default parameters, a read accepted at the end of cycle 0 selects the memory with `mem_oe_n`=0 and `mem_we_n`=1 in cycles 1 to 3. `mem_dq_in` is sampled at the end of cycle 3. `done` is 1 in cycle 4 and `rdata` then holds the sampled byte.
- R5: `rdata` keeps its value until the next read completes. Writes and idle cycles leave it unchanged.
- R6: With the default parameters, a write accepted at the end of cycle 0 proceeds as follows. Cycle 1 is the setup cycle: the memory is selected and `mem_we_n`=1. Cycles 2 and 3 are the pulse, with `mem_we_n`=0. Cycle 4 is the recovery cycle: the memory is still selected and `mem_we_n`=1. `done` is 1 in cycle 5. `mem_oe_n` stays 1 throughout the write.
- R7: `mem_dq_oe` is 1 only in cycles in which `mem_we_n` is 0 and was already 0 in the previous cycle. With the defaults this is cycle 3 of a write only, and in that cycle `mem_dq_out` carries the request's write data.
- R8: While the memory stays selected, `mem_addr` does not change, and while `mem_dq_oe` stays 1, `mem_dq_out` does not change.
- R9: A write accepted in the cycle in which a read's `done` is 1 first spends one standby cycle with the memory deselected, and its `done` comes one cycle later than usual (cycle 6). A write accepted after at least one intervening idle cycle gets no such cycle.
- R10: `done` is high for exactly one cycle per access. `ready` returns to 1 in that same cycle.
- R11: `mem_oe_n` and `mem_we_n` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when `ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| ready | output | 1 | Controller idle and able to take a request |
| done | output | 1 | One-cycle pulse when an access finishes |
| rdata | output | 8 | Byte from the most recent read |
| mem_addr | output | 17 | Memory address pins |
| mem_sel_n | output | 1 | Active-low chip enable |
| mem_sel | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable for the data bus driver |
| mem_dq_in | input | 8 | Data returned by the memory |

## Verification
Two events can fall in the same cycle. The first is the `done` of a read, with `ready` already 1. The second is the acceptance of a new write, which decides whether a turnaround cycle is inserted. The bench provokes this by presenting a write in exactly the cycle that carries the read's `done`. It judges the result by requiring the memory to stay deselected for one cycle and `done` to arrive one cycle later than for an ordinary write. The same sequence is repeated with a single idle cycle in between, and there the turnaround must not appear. A second pair is also exercised: a request that arrives while an access is in progress, against that access's completion. The bench checks that the pending access finishes with the old data and that no further access starts afterwards.

// File: rtl/asram_pkg.sv
package asram_pkg;

   typedef enum logic [2:0] {
      ST_IDLE       = 3'd0,
      ST_RD_ACCESS  = 3'd1,
      ST_RD_CAPTURE = 3'd2,
      ST_WR_SETUP   = 3'd3,
      ST_WR_PULSE   = 3'd4,
      ST_WR_RECOVER = 3'd5,
      ST_TURN       = 3'd6
   } asram_state_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_tick.sv
// Down-counter that times each phase of an access.
module asram_tick #(
   parameter int unsigned CNT_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic             expired
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign expired = (cnt == '0);

endmodule

// File: rtl/asram_dpath.sv
// Holds the request address and data, and captures read data.
module asram_dpath #(
   parameter int unsigned ADDR_W = 17,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [DATA_W-1:0] rdata_q
);

   // Address and data stay frozen for the whole access (R8).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   // Read data is replaced only at the sample cycle (R5).
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata_q <= '0;
      end else if (capture) begin
         rdata_q <= mem_dq_in;
      end
   end

endmodule

// File: rtl/asram_seq.sv
// Strobe sequencer: walks the read, write and turnaround phases.
module asram_seq
   import asram_pkg::*;
#(
   parameter int unsigned RD_WAIT  = 2,
   parameter int unsigned WR_SETUP = 1,
   parameter int unsigned WR_PULSE = 2,
   parameter int unsigned WR_HOLD  = 1,
   parameter int unsigned TURN_GAP = 1,
   parameter int unsigned CNT_W    = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [CNT_W-1:0] cnt,
   input  logic             expired,
   output asram_state_e     state,
   output logic             load,
   output logic [CNT_W-1:0] load_val,
   output logic             accept,
   output logic             capture,
   output logic             drive,
   output logic             done
);

   localparam logic [CNT_W-1:0] LD_RD = CNT_W'(RD_WAIT - 1);
   localparam logic [CNT_W-1:0] LD_WS = CNT_W'(WR_SETUP - 1);
   localparam logic [CNT_W-1:0] LD_WP = CNT_W'(WR_PULSE - 1);
   localparam logic [CNT_W-1:0] LD_WH = CNT_W'(WR_HOLD - 1);
   localparam logic [CNT_W-1:0] LD_TA = CNT_W'((TURN_GAP > 0) ? TURN_GAP - 1 : 0);

   asram_state_e state_d;
   logic         need_turn;

   // With a zero gap the turnaround tracking is left out.
   generate
      if (TURN_GAP > 0) begin : g_turn
         logic rd_recent_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               rd_recent_q <= 1'b0;
            end else if (state == ST_RD_CAPTURE) begin
               rd_recent_q <= 1'b1;
            end else if (state == ST_IDLE) begin
               rd_recent_q <= 1'b0;
            end
         end
         assign need_turn = rd_recent_q;
      end else begin : g_no_turn
         assign need_turn = 1'b0;
      end
   endgenerate

   assign accept = (state == ST_IDLE) && req_valid;

   always_comb begin
      state_d  = state;
      load     = 1'b0;
      load_val = '0;
      unique case (state)
         ST_IDLE: begin
            if (req_valid) begin
               load = 1'b1;
               if (!req_write) begin
                  state_d  = ST_RD_ACCESS;
                  load_val = LD_RD;
               end else if (need_turn) begin
                  state_d  = ST_TURN;
                  load_val = LD_TA;
               end else begin
                  state_d  = ST_WR_SETUP;
                  load_val = LD_WS;
               end
            end
         end
         ST_RD_ACCESS: begin
            if (expired) state_d = ST_RD_CAPTURE;
         end
         ST_RD_CAPTURE: begin
            state_d = ST_IDLE;
         end
         ST_TURN: begin
            if (expired) begin
               state_d  = ST_WR_SETUP;
               load     = 1'b1;
               load_val = LD_WS;
            end
         end
         ST_WR_SETUP: begin
            if (expired) begin
               state_d  = ST_WR_PULSE;
               load     = 1'b1;
               load_val = LD_WP;
            end
         end
         ST_WR_PULSE: begin
            if (expired) begin
               state_d  = ST_WR_RECOVER;
               load     = 1'b1;
               load_val = LD_WH;
            end
         end
         ST_WR_RECOVER: begin
            if (expired) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         done  <= 1'b0;
      end else begin
         state <= state_d;
         done  <= (state == ST_RD_CAPTURE) ||
                  ((state == ST_WR_RECOVER) && expired);
      end
   end

   assign capture = (state == ST_RD_CAPTURE);
   // The first pulse cycle leaves the bus to the memory as it releases it.
   assign drive   = (state == ST_WR_PULSE) && (cnt != LD_WP);

endmodule

// File: rtl/asram_port.sv
module asram_port
   import asram_pkg::*;
#(
   parameter int unsigned ADDR_W   = 17,
   parameter int unsigned DATA_W   = 8,
   parameter int unsigned RD_WAIT  = 2,
   parameter int unsigned WR_SETUP = 1,
   parameter int unsigned WR_PULSE = 2,
   parameter int unsigned WR_HOLD  = 1,
   parameter int unsigned TURN_GAP = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_sel_n,
   output logic              mem_sel,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int unsigned MAX_CYC =
      max2(max2(RD_WAIT, WR_SETUP), max2(max2(WR_PULSE, WR_HOLD), max2(TURN_GAP, 1)));
   localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);

   generate
      if (RD_WAIT < 1) begin : g_bad_rd
         $error("RD_WAIT must be at least 1");
      end
      if (WR_SETUP < 1) begin : g_bad_ws
         $error("WR_SETUP must be at least 1");
      end
      if (WR_PULSE < 2) begin : g_bad_wp
         $error("WR_PULSE must be at least 2 to leave a drive window");
      end
      if (WR_HOLD < 1) begin : g_bad_wh
         $error("WR_HOLD must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_w
         $error("address and data widths must be positive");
      end
   endgenerate

   asram_state_e     state;
   logic             load, expired, accept, capture, drive;
   logic [CNT_W-1:0] load_val, cnt;
   logic             selected;

   asram_tick #(.CNT_W(CNT_W)) i_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_val (load_val),
      .cnt      (cnt),
      .expired  (expired)
   );

   asram_seq #(
      .RD_WAIT  (RD_WAIT),
      .WR_SETUP (WR_SETUP),
      .WR_PULSE (WR_PULSE),
      .WR_HOLD  (WR_HOLD),
      .TURN_GAP (TURN_GAP),
      .CNT_W    (CNT_W)
   ) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .cnt       (cnt),
      .expired   (expired),
      .state     (state),
      .load      (load),
      .load_val  (load_val),
      .accept    (accept),
      .capture   (capture),
      .drive     (drive),
      .done      (done)
   );

   asram_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .capture   (capture),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .mem_dq_in (mem_dq_in),
      .addr_q    (mem_addr),
      .wdata_q   (mem_dq_out),
      .rdata_q   (rdata)
   );

   // Pin decode from the registered phase.
   always_comb begin
      selected  = (state != ST_IDLE) && (state != ST_TURN);
      mem_sel_n = !selected;
      mem_sel   = selected;
      mem_oe_n  = !((state == ST_RD_ACCESS) || (state == ST_RD_CAPTURE));
      mem_we_n  = !(state == ST_WR_PULSE);
      mem_dq_oe = drive;
      ready     = (state == ST_IDLE);
   end

   a_r1_idle_standby: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe));

   a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && req_valid) |=> !ready);

   a_r4_read_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (mem_we_n && !mem_sel_n && !mem_dq_oe));

   a_r5_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rdata) |-> done);

   a_r6_oe_high_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && !mem_sel_n));

   a_r7_drive_late_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      mem_dq_oe |-> (!mem_we_n && $past(!mem_we_n)));

   a_r8_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

   a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r11_no_strobe_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mem_oe_n && !mem_we_n));

endmodule

// File: tb/test_asram_port.sv
module test_asram_port;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [16:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        ready, done;
   logic [7:0]  rdata;
   logic [16:0] mem_addr;
   logic        mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [7:0]  mem_dq_out, mem_dq_in;

   int checks = 0;
   int errors = 0;
   bit mon_on = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   asram_port i_asram_port (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .ready(ready), .done(done),
      .rdata(rdata), .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
      .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out),
      .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // Memory model: stores on a driven write pulse, answers a selected read.
   logic [7:0] mem_model [logic [16:0]];
   logic [7:0] rd_val = 8'h00;
   wire        m_sel = !mem_sel_n && mem_sel;
   assign mem_dq_in = (m_sel && !mem_oe_n && mem_we_n) ? rd_val : 8'hEE;

   always @(negedge clk) begin
      if (m_sel && !mem_we_n && mem_dq_oe) mem_model[mem_addr] = mem_dq_out;
      rd_val = mem_model.exists(mem_addr) ? mem_model[mem_addr] : 8'h00;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Protocol monitor, sampled mid-cycle.
   logic        p_sel = 1'b0, p_we_low = 1'b0, p_oe = 1'b0;
   logic [16:0] p_addr = '0;
   logic [7:0]  p_dout = '0;
   always @(negedge clk) begin
      if (mon_on) begin
         chk(mem_sel_n == !mem_sel, "R2 enables paired", {mem_sel_n, mem_sel}, 2'b10);
         chk(!(!mem_oe_n && !mem_we_n), "R11 strobe overlap", {mem_oe_n, mem_we_n}, 2'b11);
         if (ready)
            chk(mem_sel_n && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 standby when ready",
                {mem_sel_n, mem_oe_n, mem_we_n, mem_dq_oe}, 4'b1110);
         if (mem_dq_oe)
            chk(!mem_we_n && p_we_low, "R7 drive window", {mem_we_n, p_we_low}, 2'b01);
         if (m_sel && p_sel)
            chk(mem_addr == p_addr, "R8 address stable", mem_addr, p_addr);
         if (mem_dq_oe && p_oe)
            chk(mem_dq_out == p_dout, "R8 data stable", mem_dq_out, p_dout);
      end
      p_sel = m_sel; p_we_low = !mem_we_n; p_oe = mem_dq_oe;
      p_addr = mem_addr; p_dout = mem_dq_out;
   end

   // Caller is mid-cycle with ready high; leaves at mid cycle 1.
   task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic do_read(input logic [16:0] a, input logic [7:0] exp);
      issue(1'b0, a, 8'h00);
      for (int k = 1; k <= 4; k++) begin
         if (k < 4) begin
            chk(!mem_oe_n && mem_we_n && !mem_sel_n && !done && !ready, "R4 read strobes",
                {mem_oe_n, mem_we_n, mem_sel_n, done, ready}, 5'b01000);
            @(negedge clk);
         end else begin
            chk(done && ready, "R4 R10 read done", {done, ready}, 2'b11);
            chk(rdata == exp, "R4 read data", rdata, exp);
         end
      end
   endtask

   task automatic do_write(input logic [16:0] a, input logic [7:0] d, input bit turn);
      int lat = turn ? 6 : 5;
      int off = turn ? 1 : 0;
      issue(1'b1, a, d);
      for (int k = 1; k <= lat; k++) begin
         chk(mem_oe_n, "R6 oe high in write", mem_oe_n, 1'b1);
         chk(done == (k == lat), "R6 R10 write done timing", done, (k == lat));
         if (turn && k == 1)
            chk(mem_sel_n && mem_we_n && !ready, "R9 turnaround standby",
                {mem_sel_n, mem_we_n, ready}, 3'b110);
         if (k == off + 1)
            chk(!mem_sel_n && mem_we_n && !mem_dq_oe, "R6 setup cycle",
                {mem_sel_n, mem_we_n, mem_dq_oe}, 3'b010);
         if (k == off + 2)
            chk(!mem_we_n && !mem_dq_oe, "R7 first pulse undriven", {mem_we_n, mem_dq_oe}, 2'b00);
         if (k == off + 3)
            chk(!mem_we_n && mem_dq_oe && mem_dq_out == d, "R7 second pulse driven",
                {mem_we_n, mem_dq_oe, mem_dq_out}, {2'b01, d});
         if (k == off + 4)
            chk(!mem_sel_n && mem_we_n && !mem_dq_oe, "R6 recovery cycle",
                {mem_sel_n, mem_we_n, mem_dq_oe}, 3'b010);
         if (k < lat) @(negedge clk);
      end
   endtask

   task automatic t_reset;
      chk(ready && !done, "R1 reset ready", {ready, done}, 2'b10);
      chk(mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 reset pins",
          {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
      chk(rdata == 8'h00, "R1 reset rdata", rdata, 8'h00);
   endtask

   task automatic t_patterns;
      do_write(17'h00000, 8'h00, 1'b0);
      do_write(17'h1FFFF, 8'hFF, 1'b0);
      do_write(17'h0AAAA, 8'hA5, 1'b0);
      do_write(17'h15555, 8'h5A, 1'b0);
      do_read(17'h1FFFF, 8'hFF);
      @(negedge clk);
      do_read(17'h00000, 8'h00);
      @(negedge clk);
      do_read(17'h15555, 8'h5A);
      @(negedge clk);
      do_read(17'h0AAAA, 8'hA5);
      @(negedge clk);
   endtask

   task automatic t_turn_and_hold;
      // write presented in the read's done cycle: turnaround (R9), rdata kept (R5)
      do_read(17'h0AAAA, 8'hA5);
      do_write(17'h01234, 8'h3C, 1'b1);
      chk(rdata == 8'hA5, "R5 rdata held after write", rdata, 8'hA5);
      repeat (3) @(negedge clk);
      chk(rdata == 8'hA5, "R5 rdata held idle", rdata, 8'hA5);
      do_read(17'h01234, 8'h3C);
      @(negedge clk);
      // one idle cycle after a read: no turnaround (R9)
      do_read(17'h00000, 8'h00);
      @(negedge clk);
      do_write(17'h00042, 8'hC3, 1'b0);
      @(negedge clk);
      do_read(17'h00042, 8'hC3);
      @(negedge clk);
   endtask

   task automatic t_busy;
      issue(1'b0, 17'h1FFFF, 8'h00);
      req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h1FFFF; req_wdata = 8'h11;
      @(negedge clk);
      chk(!ready, "R3 busy not ready", ready, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      @(negedge clk);
      chk(done && rdata == 8'hFF, "R3 pending read unaffected", {done, rdata}, {1'b1, 8'hFF});
      @(negedge clk);
      chk(!done && ready && mem_sel_n, "R3 R10 no access started",
          {done, ready, mem_sel_n}, 3'b011);
      do_read(17'h1FFFF, 8'hFF);
      @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      mon_on = 1'b1;
      t_reset();
      t_patterns();
      t_turn_and_hold();
      t_busy();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL R10 watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule